// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This controller sits on the synchronous side of a chip and runs single read and write accesses on an external 16-bit asynchronous static RAM. A request carries a write flag, an address, write data and a per-lane byte mask, and is taken on a valid/ready handshake. The controller drives the memory's two chip selects (one active low, one active high), output enable, write enable, the active-low lane enables and the address. It also drives the outgoing data bus together with a tri-state enable for the pad. Read data comes back, registered, with a one-cycle response pulse.

All timing is set in clock cycles. Each cycle count is taken from a nanosecond limit and the clock period, given in picoseconds. A count is the ceiling of the limit divided by the period, and a nonzero limit gives at least one cycle. The read phase, the write-enable pulse, the tail of the write cycle and the wait for the bus to float after a read are each counted by one shared down-counter.

Top module: `sram_ctrl`

## Requirements
- R1: A read holds both chip selects, output enable, the lane enables and the address active for exactly RD_CYC cycles. RD_CYC is the largest of the cycle counts for the read cycle time (45 ns), address-to-data (45 ns) and output-enable-to-data (22 ns). The data bus is sampled on the last of those cycles. All cycle counts are ceil(ns*1000/CLK_PS), with at least 1 for a nonzero limit.
- R2: Read data is registered on the final read cycle. `rsp_valid_o` is high for one cycle, in the cycle that follows. A lane whose mask bit is clear returns zero.
- R3: A write asserts write enable, both chip selects, the lane enables, the address and the driven data on the same clock edge. It holds write enable low for exactly WR_CYC cycles. WR_CYC is the largest of the counts for the pulse width (35 ns), address-to-end (35 ns), lane-to-end (35 ns) and data setup (25 ns). Write enable, the selects and the lane enables are then all released on one edge.
- R4: `sram_dq_oe_o` is high only while write enable is low. It falls on the edge where write enable rises, and is never high while output enable is low.
- R5: After a read, the data bus is not driven until output enable has been high for at least HZ_CYC cycles (18 ns).
- R6: Two chip-select falling edges are at least WC_CYC cycles apart (45 ns).
- R7: Mask bit 0 selects data bits [7:0] and lane enable bit 0. Mask bit 1 selects bits [15:8] and lane enable bit 1. Lane enables are active low. Only enabled lanes are written in memory.
- R8: The lane enables never change while the chip is deselected in both the previous and the current cycle.
- R9: The address stays stable for as long as the chip remains selected.
- R10: A request with an all-zero mask is accepted and produces no chip select. As a write it changes nothing in memory. As a read it gives `rsp_valid_o` in the next cycle with data zero.
- R11: After reset, all strobes are inactive, the bus is not driven and `req_ready_o` is high. `req_ready_o` is high only while no access or recovery phase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request taken when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | LANES*LANE_W | Write data |
| req_be_i | input | LANES | Lane mask, active high |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | LANES*LANE_W | Registered read data |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_sel_n_o | output | 1 | Chip select, active low |
| sram_sel_o | output | 1 | Chip select, active high |
| sram_outen_n_o | output | 1 | Output enable, active low |
| sram_wren_n_o | output | 1 | Write enable, active low |
| sram_lane_n_o | output | LANES | Lane enables, active low |
| sram_dq_o | output | LANES*LANE_W | Outgoing data |
| sram_dq_oe_o | output | 1 | Pad drive enable for `sram_dq_o` |
| sram_dq_i | input | LANES*LANE_W | Incoming data from the pad |

## Verification
The bench builds the controller with an 8-bit address and the default limits, at a 5000 ps period. This gives a 9-cycle read phase, a 7-cycle write pulse, a 2-cycle write tail and a 4-cycle float wait, so every count is distinct. It also means that sampling the bus one cycle early, or driving it too soon after a read, shows up as wrong data or a reported violation. The small address space lets a complete memory model track every word. That model returns garbage until the access has been held long enough, and it commits writes only on the rising edge of write enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_GAP
  } seq_state_e;

  // ceil(ns / period), zero stays zero
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    if (ns == 0) return 0;
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [LANES-1:0]        cap_be_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= '0;
      else if (cap_i) lane_q <= cap_be_i[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
    end
    assign rdata_o[l*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RD_M1  = 8,
  parameter int unsigned WR_M1  = 6,
  parameter int unsigned HZ_M1  = 3,
  parameter int unsigned GAP_M1 = 1,
  parameter bit          GAP_EN = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LANES*LANE_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]        req_be_i,
  output logic                    req_ready_o,
  output logic                    tmr_load_o,
  output logic [CNT_W-1:0]        tmr_val_o,
  input  logic                    tmr_done_i,
  output logic                    cap_o,
  output logic [LANES-1:0]        cap_be_o,
  output logic                    rsp_valid_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic                    sel_n_o,
  output logic                    sel_o,
  output logic                    outen_n_o,
  output logic                    wren_n_o,
  output logic [LANES-1:0]        lane_n_o,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);

  localparam logic [CNT_W-1:0] RD_L  = CNT_W'(RD_M1);
  localparam logic [CNT_W-1:0] WR_L  = CNT_W'(WR_M1);
  localparam logic [CNT_W-1:0] HZ_L  = CNT_W'(HZ_M1);
  localparam logic [CNT_W-1:0] GAP_L = CNT_W'(GAP_M1);

  seq_state_e state_q;
  logic [LANES-1:0] be_q;
  logic accept, null_req, end_rd, end_wr;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign null_req    = (req_be_i == '0);
  assign end_rd      = (state_q == ST_READ)  && tmr_done_i;
  assign end_wr      = (state_q == ST_WRITE) && tmr_done_i;

  always_comb begin
    tmr_load_o = (accept && !null_req) || end_rd || end_wr;
    unique case (state_q)
      ST_IDLE: tmr_val_o = req_we_i ? WR_L : RD_L;
      ST_READ: tmr_val_o = HZ_L;
      default: tmr_val_o = GAP_L;
    endcase
  end

  // zero-mask reads capture with an empty mask, giving zero
  assign cap_o    = end_rd || (accept && null_req && !req_we_i);
  assign cap_be_o = req_ready_o ? req_be_i : be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      be_q        <= '0;
      addr_o      <= '0;
      dq_o        <= '0;
      sel_n_o     <= 1'b1;
      sel_o       <= 1'b0;
      outen_n_o   <= 1'b1;
      wren_n_o    <= 1'b1;
      lane_n_o    <= '1;
      dq_oe_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= cap_o;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !null_req) begin
            addr_o   <= req_addr_i;
            be_q     <= req_be_i;
            lane_n_o <= ~req_be_i;
            sel_n_o  <= 1'b0;
            sel_o    <= 1'b1;
            if (req_we_i) begin
              dq_o     <= req_wdata_i;
              wren_n_o <= 1'b0;
              dq_oe_o  <= 1'b1;
              state_q  <= ST_WRITE;
            end else begin
              outen_n_o <= 1'b0;
              state_q   <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (tmr_done_i) begin
            sel_n_o   <= 1'b1;
            sel_o     <= 1'b0;
            outen_n_o <= 1'b1;
            lane_n_o  <= '1;
            state_q   <= ST_GAP;
          end
        end
        ST_WRITE: begin
          if (tmr_done_i) begin
            wren_n_o <= 1'b1;
            dq_oe_o  <= 1'b0;
            sel_n_o  <= 1'b1;
            sel_o    <= 1'b0;
            lane_n_o <= '1;
            state_q  <= GAP_EN ? ST_GAP : ST_IDLE;
          end
        end
        default: begin
          if (tmr_done_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned LANES    = 2,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned T_RC_NS  = 45,
  parameter int unsigned T_AA_NS  = 45,
  parameter int unsigned T_DOE_NS = 22,
  parameter int unsigned T_WC_NS  = 45,
  parameter int unsigned T_PWE_NS = 35,
  parameter int unsigned T_AW_NS  = 35,
  parameter int unsigned T_BW_NS  = 35,
  parameter int unsigned T_SD_NS  = 25,
  parameter int unsigned T_HZ_NS  = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LANES*LANE_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]        req_be_i,
  output logic                    rsp_valid_o,
  output logic [LANES*LANE_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0]       sram_addr_o,
  output logic                    sram_sel_n_o,
  output logic                    sram_sel_o,
  output logic                    sram_outen_n_o,
  output logic                    sram_wren_n_o,
  output logic [LANES-1:0]        sram_lane_n_o,
  output logic [LANES*LANE_W-1:0] sram_dq_o,
  output logic                    sram_dq_oe_o,
  input  logic [LANES*LANE_W-1:0] sram_dq_i
);

  localparam int unsigned RD_CYC = max_u(max_u(ns_to_cyc(T_RC_NS, CLK_PS), ns_to_cyc(T_AA_NS, CLK_PS)),
                                         max_u(ns_to_cyc(T_DOE_NS, CLK_PS), 1));
  localparam int unsigned WR_CYC = max_u(max_u(ns_to_cyc(T_PWE_NS, CLK_PS), ns_to_cyc(T_AW_NS, CLK_PS)),
                                         max_u(max_u(ns_to_cyc(T_BW_NS, CLK_PS), ns_to_cyc(T_SD_NS, CLK_PS)), 1));
  localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_PS);
  localparam int unsigned HZ_CYC = max_u(ns_to_cyc(T_HZ_NS, CLK_PS), 1);
  localparam int unsigned GAP_WR = (WC_CYC > WR_CYC) ? WC_CYC - WR_CYC : 0;
  localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WR_CYC), max_u(HZ_CYC, GAP_WR));
  localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

  logic                 tmr_load, tmr_done, cap;
  logic [CNT_W-1:0]     tmr_val;
  logic [LANES-1:0]     cap_be;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_ctrl_seq #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .CNT_W  (CNT_W),
    .RD_M1  (RD_CYC - 1),
    .WR_M1  (WR_CYC - 1),
    .HZ_M1  (HZ_CYC - 1),
    .GAP_M1 ((GAP_WR > 0) ? GAP_WR - 1 : 0),
    .GAP_EN (GAP_WR > 0)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .req_ready_o (req_ready_o),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .tmr_done_i  (tmr_done),
    .cap_o       (cap),
    .cap_be_o    (cap_be),
    .rsp_valid_o (rsp_valid_o),
    .addr_o      (sram_addr_o),
    .sel_n_o     (sram_sel_n_o),
    .sel_o       (sram_sel_o),
    .outen_n_o   (sram_outen_n_o),
    .wren_n_o    (sram_wren_n_o),
    .lane_n_o    (sram_lane_n_o),
    .dq_o        (sram_dq_o),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .cap_be_i (cap_be),
    .dq_i     (sram_dq_i),
    .rdata_o  (rsp_rdata_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned WR_CYC = 7,
  parameter int unsigned HZ_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_sel_n_o,
  input logic              sram_sel_o,
  input logic              sram_outen_n_o,
  input logic              sram_wren_n_o,
  input logic [LANES-1:0]  sram_lane_n_o,
  input logic              sram_dq_oe_o
);

  localparam int unsigned CW = $clog2(RD_CYC + WR_CYC + HZ_CYC + 2) + 1;
  localparam logic [CW-1:0] RD_L  = CW'(RD_CYC);
  localparam logic [CW-1:0] WR_L  = CW'(WR_CYC);
  localparam logic [CW-1:0] HZ_L  = CW'(HZ_CYC);
  localparam logic [CW-1:0] SAT_L = '1;

  logic [CW-1:0] we_run, oe_run, off_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run  <= '0;
      oe_run  <= '0;
      off_run <= SAT_L;
    end else begin
      we_run  <= !sram_wren_n_o  ? ((we_run  == SAT_L) ? SAT_L : we_run  + 1'b1) : '0;
      oe_run  <= !sram_outen_n_o ? ((oe_run  == SAT_L) ? SAT_L : oe_run  + 1'b1) : '0;
      off_run <=  sram_outen_n_o ? ((off_run == SAT_L) ? SAT_L : off_run + 1'b1) : '0;
    end
  end

  a_r1_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(!sram_outen_n_o)) |-> (oe_run >= RD_L));

  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_wren_n_o) |-> (we_run >= WR_L));

  a_r3_write_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_wren_n_o |-> (!sram_sel_n_o && sram_sel_o && (sram_lane_n_o != '1)));

  a_r4_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_outen_n_o && !sram_wren_n_o));

  a_r4_release_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_wren_n_o) |-> !sram_dq_oe_o);

  a_r5_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (off_run >= HZ_L));

  a_r8_lanes_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sram_sel_n_o) && sram_sel_n_o) |-> $stable(sram_lane_n_o));

  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!sram_sel_n_o) && !sram_sel_n_o) |-> $stable(sram_addr_o));

  a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_sel_n_o && sram_wren_n_o && sram_outen_n_o && !sram_dq_oe_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .RD_CYC (RD_CYC),
  .WR_CYC (WR_CYC),
  .HZ_CYC (HZ_CYC)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .sram_addr_o    (sram_addr_o),
  .sram_sel_n_o   (sram_sel_n_o),
  .sram_sel_o     (sram_sel_o),
  .sram_outen_n_o (sram_outen_n_o),
  .sram_wren_n_o  (sram_wren_n_o),
  .sram_lane_n_o  (sram_lane_n_o),
  .sram_dq_oe_o   (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW    = 8;
  localparam int RD_N  = (45 * 1000 + 4999) / 5000;  // 9
  localparam int DOE_N = (22 * 1000 + 4999) / 5000;  // 5
  localparam int WR_N  = (35 * 1000 + 4999) / 5000;  // 7
  localparam int WC_N  = (45 * 1000 + 4999) / 5000;  // 9
  localparam int HZ_N  = (18 * 1000 + 4999) / 5000;  // 4

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] m_addr;
  logic sel_n, sel, oe_n, we_n, dq_oe;
  logic [1:0] lane_n;
  logic [15:0] dq_out, dq_in;

  always #2.5 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .CLK_PS(5000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(m_addr), .sram_sel_n_o(sel_n), .sram_sel_o(sel),
    .sram_outen_n_o(oe_n), .sram_wren_n_o(we_n), .sram_lane_n_o(lane_n),
    .sram_dq_o(dq_out), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory and reference
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    ref_mem[i] = mem[i];
  end

  wire chip_on = !sel_n && sel;
  int ce_run = 0, oe_run = 0;
  always @(posedge clk) begin
    ce_run <= chip_on ? ce_run + 1 : 0;
    oe_run <= (chip_on && !oe_n) ? oe_run + 1 : 0;
  end

  // valid data only once the access has been held long enough
  assign dq_in = (chip_on && !oe_n && ce_run >= RD_N - 1 && oe_run >= DOE_N - 1) ?
                 {lane_n[1] ? 8'hEE : mem[m_addr][15:8], lane_n[0] ? 8'hEE : mem[m_addr][7:0]} :
                 16'hBAD0;

  // scoreboard and protocol monitor
  logic [15:0] exp_q [$];
  logic p_sel_n = 1, p_we_n = 1, p_oe_n = 1, p_dq_oe = 0, p_on = 0;
  logic [1:0] p_lane_n = 2'b11;
  logic [AW-1:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  int oe_low = 0, we_low = 0, oe_off = 100, since_sel = 100, n_acc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected response", 32'(rsp_rdata), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R2/R7 read data", 32'(rsp_rdata), 32'(e));
        end
      end
      if (!p_oe_n && oe_n) check(oe_low == RD_N, "R1 read phase length", oe_low, RD_N);
      if (!p_we_n && we_n) begin
        check(we_low == WR_N, "R3 write pulse length", we_low, WR_N);
        check(p_dq_oe && p_on && p_lane_n != 2'b11, "R3 write strobes aligned", {p_dq_oe, p_on, p_lane_n}, 4'b1100);
        check(!dq_oe && sel_n && lane_n == 2'b11, "R4 release with write end", {dq_oe, sel_n, lane_n}, 4'b0111);
        if (!p_lane_n[0]) mem[p_addr][7:0]  = p_dq[7:0];
        if (!p_lane_n[1]) mem[p_addr][15:8] = p_dq[15:8];
      end
      if (dq_oe && (!oe_n || we_n)) check(0, "R4 bus driven outside write", {oe_n, we_n}, 2'b10);
      if (dq_oe && !p_dq_oe) check(oe_off >= HZ_N, "R5 turnaround", oe_off, HZ_N);
      if (!sel_n && p_sel_n) begin
        n_acc++;
        check(since_sel + 1 >= WC_N, "R6 access spacing", since_sel + 1, WC_N);
      end
      if (sel_n && p_sel_n && lane_n != p_lane_n) check(0, "R8 lanes toggled while deselected", lane_n, p_lane_n);
      if (!sel_n && !p_sel_n && m_addr != p_addr) check(0, "R9 address moved", m_addr, p_addr);
      oe_low    = !oe_n ? oe_low + 1 : 0;
      we_low    = !we_n ? we_low + 1 : 0;
      oe_off    = oe_n ? oe_off + 1 : 0;
      since_sel = (!sel_n && p_sel_n) ? 0 : since_sel + 1;
    end
    p_sel_n = sel_n; p_we_n = we_n; p_oe_n = oe_n; p_dq_oe = dq_oe;
    p_on = chip_on; p_lane_n = lane_n; p_addr = m_addr; p_dq = dq_out;
  end

  // driver
  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    if (be[0]) ref_mem[a][7:0]  = d[7:0];
    if (be[1]) ref_mem[a][15:8] = d[15:8];
    issue(1, a, d, be);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be);
    exp_q.push_back({be[1] ? ref_mem[a][15:8] : 8'h00, be[0] ? ref_mem[a][7:0] : 8'h00});
    issue(0, a, '0, be);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    logic [15:0] lfsr;
    int acc0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(sel_n && !sel && oe_n && we_n, "R11 strobes idle", {sel_n, sel, oe_n, we_n}, 4'b1011);
    check(lane_n == 2'b11 && !dq_oe, "R11 lanes and bus idle", {lane_n, dq_oe}, 3'b110);
    check(!rsp_valid, "R11 no response", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R11 ready after reset", req_ready, 1);

    do_write(8'h10, 16'h1234, 2'b11);
    do_read(8'h10, 2'b11);
    do_write(8'h10, 16'hAB99, 2'b10);          // R7 upper lane only
    do_read(8'h10, 2'b01);
    do_read(8'h10, 2'b10);
    do_read(8'h10, 2'b11);
    drain();

    // R10 zero-mask requests
    acc0 = n_acc;
    do_write(8'h10, 16'hFFFF, 2'b00);
    do_read(8'h10, 2'b00);
    drain();
    check(n_acc == acc0, "R10 no chip select", n_acc, acc0);
    do_read(8'h10, 2'b11);

    // boundary addresses, write right after read (R5)
    do_write(8'h00, 16'h0F0F, 2'b11);
    do_write(8'hFF, 16'hC3A5, 2'b01);
    do_read(8'hFF, 2'b11);
    do_write(8'h55, 16'h7E81, 2'b11);
    do_read(8'h00, 2'b11);
    do_read(8'h55, 2'b11);
    drain();

    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) do_write(lfsr[11:4], lfsr ^ 16'h3C3C, lfsr[3:2]);
      else         do_read(lfsr[11:4], lfsr[3:2]);
    end
    drain();
    check(req_ready && !rsp_valid, "R11 idle at end", {req_ready, rsp_valid}, 2'b10);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule